// File: doc/BRIEF.md
# Valley-Select Hysteretic Up/Down Counter

This block decides how many ringing valleys a quasi-resonant switching controller lets pass before it turns its power switch back on. Three comparator flags are derived from the feedback level: above the lower, the middle and the upper threshold. These flags are synchronised and held as "seen" bits across a long evaluation period. At the end of each period the counter climbs, holds, descends or snaps to its floor, depending on the highest threshold that was crossed at any time in that period.

The gap between the threshold that stops the climb and the threshold that starts the descent forms a hysteresis band, so a feedback level near one threshold does not make the valley count dither. A line-range select moves the allowed window between a low-line range and a high-line range. The period is produced inside the block by a prescaler whose length is a parameter. The default gives 48 ms at a 125 MHz clock, and the bench uses a short period.

Top module: `valley_count_ctrl`

## Requirements
- R1: While reset is asserted the count output is 1.
- R2: The count changes only on the last clock cycle of each evaluation period (every PERIOD_CYCLES cycles after reset release), except for the floor raise of R9.
- R3: If no flag was seen during a period, the count rises by one at the period end and saturates at the range maximum.
- R4: If the lower-threshold flag was seen but the middle one was not, the count keeps its value at the period end.
- R5: If the middle-threshold flag was seen but the upper one was not, the count falls by one at the period end and saturates at the range minimum.
- R6: If the upper-threshold flag was seen at any time in the period, the count is set to the range minimum at the period end.
- R7: With line select low (low line) the range is 1 to 8. With line select high (high line) the range is 3 to 10.
- R8: A flag asserted for a single cycle anywhere in a period counts for that whole period, and the seen bits are cleared at each period end.
- R9: When the line select goes high and the count is below 3, the count becomes 3 on the next clock edge. A count above 8 after a switch to low line is clamped at the next period end.
- R10: Each flag passes two synchroniser flops, so a flag arriving in the final two cycles of a period is counted in the following period.
- R11: The upper flag takes precedence over the middle flag, and the middle flag takes precedence over the lower flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low start-up reset |
| hiline_i | input | 1 | Line range select: 0 low line, 1 high line |
| fb_lo_i | input | 1 | Feedback above lower threshold (asynchronous) |
| fb_mid_i | input | 1 | Feedback above middle threshold (asynchronous) |
| fb_hi_i | input | 1 | Feedback above upper threshold (asynchronous) |
| count_o | output | CW | Current valley count |

## Verification
The assertions assume that the line select is a quasi-static, already synchronous level. They also assume that the three flags are nested, meaning a higher flag normally comes with the lower ones. They check the step rules only when the count already lies inside the selected range, because the clamp after a line change is a separate rule. The stimulus changes the line select and the flags only on the falling clock edge. It places single-cycle pulses both mid-period and in the last cycle of a period, and it also drives deliberately non-nested flag patterns to exercise precedence.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    // Period-end decision, in order of increasing precedence
    typedef enum logic [1:0] {
        ACT_UP   = 2'd0,
        ACT_HOLD = 2'd1,
        ACT_DOWN = 2'd2,
        ACT_SNAP = 2'd3
    } act_e;

    // Bit positions of the level flags inside a 3-bit vector
    localparam int LVL_LO  = 0;
    localparam int LVL_MID = 1;
    localparam int LVL_HI  = 2;
    localparam int LVL_N   = 3;

    function automatic act_e pick_action(input logic [LVL_N-1:0] hit);
        if (hit[LVL_HI])       return ACT_SNAP;
        else if (hit[LVL_MID]) return ACT_DOWN;
        else if (hit[LVL_LO])  return ACT_HOLD;
        else                   return ACT_UP;
    endfunction

endpackage

// File: rtl/vsc_sync.sv
module vsc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/vsc_prescaler.sv
module vsc_prescaler #(
    parameter int PERIOD_CYCLES = 6_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int PW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD_CYCLES - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        at_end = (st_q.cnt == LAST);
        st_d   = st_q;
        if (at_end) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = at_end;
endmodule

// File: rtl/vsc_peak_hold.sv
module vsc_peak_hold #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] hit_o,
    output logic [N-1:0] seen_o
);
    typedef struct packed {
        logic [N-1:0] seen;
    } ph_st_t;

    ph_st_t       st_d, st_q;
    logic [N-1:0] merged;

    // R8: sticky capture, consumed and cleared at the period end
    always_comb begin
        merged = st_q.seen | lvl_i;
        st_d   = st_q;
        if (tick_i) st_d.seen = '0;
        else        st_d.seen = merged;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hit_o  = merged;
    assign seen_o = st_q.seen;
endmodule

// File: rtl/vsc_step.sv
module vsc_step
    import vsc_pkg::*;
#(
    parameter int CW     = 4,
    parameter int LO_MIN = 1,
    parameter int LO_MAX = 8,
    parameter int HI_MIN = 3,
    parameter int HI_MAX = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             hiline_i,
    input  logic [LVL_N-1:0] hit_i,
    output logic [CW-1:0]    count_o
);
    localparam logic [CW-1:0] LO_MIN_C = CW'(LO_MIN);
    localparam logic [CW-1:0] LO_MAX_C = CW'(LO_MAX);
    localparam logic [CW-1:0] HI_MIN_C = CW'(HI_MIN);
    localparam logic [CW-1:0] HI_MAX_C = CW'(HI_MAX);

    typedef struct packed {
        logic [CW-1:0] count;
    } step_st_t;

    step_st_t      st_d, st_q;
    logic [CW-1:0] floor_c, ceil_c, base;
    act_e          act;

    always_comb begin
        floor_c = hiline_i ? HI_MIN_C : LO_MIN_C;   // R7
        ceil_c  = hiline_i ? HI_MAX_C : LO_MAX_C;
        base    = st_q.count;
        if (base < floor_c) base = floor_c;
        if (base > ceil_c)  base = ceil_c;          // R9 clamp at update
        act  = pick_action(hit_i);                  // R11
        st_d = st_q;
        if (tick_i) begin
            unique case (act)
                ACT_UP:   st_d.count = (base == ceil_c)  ? base : base + 1'b1; // R3
                ACT_HOLD: st_d.count = base;                                  // R4
                ACT_DOWN: st_d.count = (base == floor_c) ? base : base - 1'b1; // R5
                ACT_SNAP: st_d.count = floor_c;                               // R6
                default:  st_d.count = base;
            endcase
        end else if (st_q.count < floor_c) begin
            st_d.count = floor_c;                   // R9 immediate floor raise
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.count <= LO_MIN_C;        // R1
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/valley_count_ctrl.sv
module valley_count_ctrl
    import vsc_pkg::*;
#(
    parameter int PERIOD_CYCLES = 6_000_000,
    parameter int SYNC_STAGES   = 2,
    parameter int LO_MIN        = 1,
    parameter int LO_MAX        = 8,
    parameter int HI_MIN        = 3,
    parameter int HI_MAX        = 10,
    parameter int CW            = $clog2(HI_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hiline_i,
    input  logic          fb_lo_i,
    input  logic          fb_mid_i,
    input  logic          fb_hi_i,
    output logic [CW-1:0] count_o
);
    logic [LVL_N-1:0] raw_lvl, sync_lvl, hit, seen;
    logic             tick;

    always_comb begin
        raw_lvl          = '0;
        raw_lvl[LVL_LO]  = fb_lo_i;
        raw_lvl[LVL_MID] = fb_mid_i;
        raw_lvl[LVL_HI]  = fb_hi_i;
    end

    // R10
    vsc_sync #(.W(LVL_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(raw_lvl),
        .sync_o (sync_lvl)
    );

    // R2
    vsc_prescaler #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    vsc_peak_hold #(.N(LVL_N)) u_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick),
        .lvl_i (sync_lvl),
        .hit_o (hit),
        .seen_o(seen)
    );

    vsc_step #(
        .CW(CW), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX),
        .HI_MIN(HI_MIN), .HI_MAX(HI_MAX)
    ) u_step (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .hiline_i(hiline_i),
        .hit_i   (hit),
        .count_o (count_o)
    );
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
    parameter int CW     = 4,
    parameter int LO_MIN = 1,
    parameter int LO_MAX = 8,
    parameter int HI_MIN = 3,
    parameter int HI_MAX = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          hiline_i,
    input logic          tick_i,
    input logic [2:0]    hit_i,
    input logic [2:0]    seen_i,
    input logic [CW-1:0] count_i
);
    localparam logic [CW-1:0] LMIN = CW'(LO_MIN);
    localparam logic [CW-1:0] LMAX = CW'(LO_MAX);
    localparam logic [CW-1:0] HMIN = CW'(HI_MIN);
    localparam logic [CW-1:0] HMAX = CW'(HI_MAX);

    logic [CW-1:0] flo, fhi;
    logic          in_rng;
    always_comb begin
        flo    = hiline_i ? HMIN : LMIN;
        fhi    = hiline_i ? HMAX : LMAX;
        in_rng = (count_i >= flo) && (count_i <= fhi);
    end

    AST_QUIET_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && count_i >= flo) |=> $stable(count_i)); // R2

    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hit_i == 3'b000 && in_rng && count_i < fhi) |=> count_i == $past(count_i) + 1'b1); // R3

    AST_HOLD_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hit_i == 3'b001 && in_rng) |=> $stable(count_i)); // R4

    AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hit_i[2:1] == 2'b01 && in_rng && count_i > flo) |=> count_i == $past(count_i) - 1'b1); // R5

    AST_SNAP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && hit_i[2] && !hiline_i) |=> count_i == LMIN); // R6

    AST_GLOBAL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i >= LMIN) && (count_i <= HMAX)); // R7

    AST_SEEN_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> seen_i == 3'b000); // R8

    AST_HILINE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hiline_i |=> count_i >= HMIN); // R9
endmodule

bind valley_count_ctrl vsc_checker #(
    .CW(CW), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .HI_MIN(HI_MIN), .HI_MAX(HI_MAX)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hiline_i(hiline_i),
    .tick_i  (tick),
    .hit_i   (hit),
    .seen_i  (seen),
    .count_i (count_o)
);

// File: tb/tb_valley_count_ctrl.sv
`timescale 1ns/1ps
module tb_valley_count_ctrl;
    localparam int P  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hiline = 1'b0;
    logic          f_lo = 1'b0, f_mid = 1'b0, f_hi = 1'b0;
    logic [CW-1:0] count;

    always #4 clk = ~clk;   // 125 MHz

    valley_count_ctrl #(.PERIOD_CYCLES(P)) dut (
        .clk_i(clk), .rst_ni(rst_n), .hiline_i(hiline),
        .fb_lo_i(f_lo), .fb_mid_i(f_mid), .fb_hi_i(f_hi),
        .count_o(count)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int       m_ph = 0;
    int       m_cnt = 1;
    bit [2:0] m_d1 = 0, m_d2 = 0, m_seen = 0, m_h;
    int       m_lo, m_hi, m_b;
    bit       m_tk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 1; m_d1 = 0; m_d2 = 0; m_seen = 0;
        end else begin
            m_h  = m_seen | m_d2;
            m_lo = hiline ? 3 : 1;
            m_hi = hiline ? 10 : 8;
            m_tk = (m_ph == P - 1);
            if (m_tk) begin
                m_b = m_cnt;
                if (m_b < m_lo) m_b = m_lo;
                if (m_b > m_hi) m_b = m_hi;
                if (m_h[2])      m_cnt = m_lo;
                else if (m_h[1]) m_cnt = (m_b > m_lo) ? m_b - 1 : m_b;
                else if (m_h[0]) m_cnt = m_b;
                else             m_cnt = (m_b < m_hi) ? m_b + 1 : m_b;
                m_seen = 0;
            end else begin
                if (m_cnt < m_lo) m_cnt = m_lo;
                m_seen = m_h;
            end
            m_ph = m_tk ? 0 : m_ph + 1;
            m_d2 = m_d1;
            m_d1 = {f_hi, f_mid, f_lo};
        end
    end

    // Per-cycle comparison against the model, tagged with the active requirement
    always @(negedge clk) begin
        if (!done) chk(int'(count) == m_cnt, cur_req, int'(count), m_cnt);
    end

    task automatic set_flags(input bit lo, input bit mid, input bit hi);
        f_lo = lo; f_mid = mid; f_hi = hi;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        @(negedge clk);
        while (m_ph != ph) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset value
        wait_cyc(5);
        chk(count == 4'd1, "R1", int'(count), 1);
        rst_n = 1'b1;

        // R3 / R7: climb to low-line ceiling
        cur_req = "R3";
        wait_cyc(12 * P);
        chk(count == 4'd8, "R3", int'(count), 8);

        // R4: hysteresis band holds
        cur_req = "R4";
        set_flags(1, 0, 0);
        wait_cyc(3 * P);
        chk(count == 4'd8, "R4", int'(count), 8);

        // R5: descend to floor and stay
        cur_req = "R5";
        set_flags(1, 1, 0);
        wait_cyc(10 * P);
        chk(count == 4'd1, "R5", int'(count), 1);

        // R3: climb a little
        cur_req = "R3";
        set_flags(0, 0, 0);
        wait_cyc(4 * P);

        // R11: non-nested patterns, upper wins over middle, middle over lower
        cur_req = "R11";
        set_flags(0, 1, 1);
        wait_cyc(2 * P);
        chk(count == 4'd1, "R11", int'(count), 1);
        cur_req = "R3";
        set_flags(0, 0, 0);
        wait_cyc(4 * P);
        cur_req = "R11";
        set_flags(1, 1, 0);
        wait_cyc(P);
        set_flags(0, 0, 0);

        // R6: upper flag snaps to floor
        cur_req = "R3";
        wait_cyc(3 * P);
        cur_req = "R6";
        set_flags(1, 1, 1);
        wait_cyc(2 * P);
        chk(count == 4'd1, "R6", int'(count), 1);

        // R8: single-cycle pulses mid-period
        cur_req = "R8";
        set_flags(0, 0, 0);
        wait_cyc(5 * P);
        wait_phase(P / 2);
        f_mid = 1'b1; @(negedge clk); f_mid = 1'b0;
        wait_cyc(2 * P);
        wait_phase(3);
        f_lo = 1'b1; @(negedge clk); f_lo = 1'b0;
        wait_cyc(2 * P);

        // R10: pulse in the final cycle lands in the next period
        cur_req = "R10";
        wait_phase(P - 1);
        f_hi = 1'b1; @(negedge clk); f_hi = 1'b0;
        wait_cyc(2 * P);
        wait_phase(P - 3);
        f_mid = 1'b1; @(negedge clk); f_mid = 1'b0;
        wait_cyc(2 * P);

        // R9: switch to high line raises floor on the next edge
        cur_req = "R9";
        set_flags(0, 0, 1);
        wait_cyc(2 * P);
        hiline = 1'b1;
        wait_cyc(2);
        chk(count == 4'd3, "R9", int'(count), 3);

        // R7: high-line ceiling
        cur_req = "R7";
        set_flags(0, 0, 0);
        wait_cyc(12 * P);
        chk(count == 4'd10, "R7", int'(count), 10);

        // R9: back to low line, clamp at the next period end
        cur_req = "R9";
        set_flags(1, 0, 0);
        hiline = 1'b0;
        wait_cyc(2 * P);
        chk(count == 4'd8, "R9", int'(count), 8);

        // R5 at high line: floor is 3
        cur_req = "R5";
        hiline = 1'b1;
        set_flags(1, 1, 0);
        wait_cyc(10 * P);
        chk(count == 4'd3, "R5", int'(count), 3);

        // R1: reset again returns to 1
        cur_req = "R1";
        rst_n = 1'b0;
        wait_cyc(2);
        chk(count == 4'd1, "R1", int'(count), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule